// File: doc/BRIEF.md
# Dual-Width Virtual Machine Arithmetic Unit

This block executes the arithmetic instruction group of a 64-bit register virtual machine. For each operation it takes the current destination register value and a second operand. The second operand is either a register value or a 32-bit immediate that is sign-extended to 64 bits. A 4-bit operation code and a class bit choose the operation and the width: 32-bit or 64-bit. The block returns the new destination value together with a write-enable flag. The register file that surrounds the unit applies the value only when write-enable is high.

One datapath serves both classes. In the 32-bit class the operands are cut to their low halves and the result is zero-extended. Most operations complete in one registered cycle. Unsigned divide and modulo run on an iterative restoring divider. While the divider works the unit reports busy, and it ignores new requests. A zero divisor never starts the divider: the unit answers at once with write-enable low, so the destination keeps its value. A byte-swap operation converts the destination to a little-endian or big-endian target at a width chosen by the immediate.

Top module: `vm_alu`

## Requirements
- R1: While reset is asserted and after it is released, before any request, `done`, `wr_en` and `busy` are low and `result` is zero.
- R2: In the 64-bit class (`is64`=1), codes 0x0 add, 0x1 subtract and 0x2 multiply produce the low 64 bits of the true result. Overflow and underflow wrap with no other effect.
- R3: In the 32-bit class (`is64`=0), every operation except byte swap works on the low 32 bits of both operands. The result wraps at 32 bits and is zero-extended into the 64-bit result.
- R4: With `src_sel`=0 the second operand is `imm` sign-extended to 64 bits. With `src_sel`=1 it is `src_val`.
- R5: Code 0x4 is OR, 0x5 is AND, 0xA is XOR, 0x8 negates the destination (two's complement), and 0xB copies the second operand.
- R6: Code 0x6 shifts left, 0x7 shifts right logically and 0xC shifts right arithmetically. The shift amount is the second operand masked to 6 bits in the 64-bit class and to 5 bits in the 32-bit class. In the 32-bit class the arithmetic shift fills from bit 31.
- R7: Code 0x3 is unsigned divide, returning the quotient, and 0x9 is unsigned modulo, returning the remainder. With a nonzero divisor, `done` rises 65 clock edges after the accepting edge in the 64-bit class and 33 edges after it in the 32-bit class, with `wr_en` high. `busy` is high in between.
- R8: A divide or modulo whose divisor, at the class width, is zero, and any request with code 0xE or 0xF, completes like a single-cycle operation. It gives `wr_en` low and returns `dst_val` unchanged on `result`.
- R9: Code 0xD swaps bytes. `imm` equal to 16 or 32 selects that width, and any other value selects 64. With `src_sel`=0 the low width bits of `dst_val` are kept and zero-extended (little-endian target). With `src_sel`=1 the bytes within the width are reversed and zero-extended (big-endian target). The class bit has no effect on this operation.
- R10: For every single-cycle operation, `done` and `result` are updated by the clock edge that samples `start`, so `done` is high for the next cycle. `wr_en` is high only while `done` is high.
- R11: A `start` that arrives while `busy` is high is ignored. No extra `done` occurs, and the running divide still returns its own result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request strobe, accepted when `busy` is low |
| op | input | 4 | Operation code |
| is64 | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| src_sel | input | 1 | Second operand from register (1) or immediate (0); endianness target for byte swap |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| busy | output | 1 | Divider running; requests ignored |
| done | output | 1 | One-cycle completion strobe |
| wr_en | output | 1 | Destination write enable, valid with `done` |
| result | output | 64 | New destination value |

## Verification
Each arithmetic operation is run with operands that carry across bit 31 or bit 63. These cases separate a correct wrap at the class width from a leak into the upper half. The immediate cases use negative values, which expose a missing sign extension. Shift amounts just above the class width show whether the mask is applied. The divider is run in both classes with the full-range value all-ones, and with divisors that are zero only in their low half. Together these separate correct quotients and latencies from a wrong iteration count or a wrong zero test. The byte-swap patterns use distinct bytes at every width and in both directions, so any misplaced lane shows up.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;
  localparam int XLEN = 64;

  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_SUB  = 4'h1;
  localparam logic [3:0] OP_MUL  = 4'h2;
  localparam logic [3:0] OP_DIV  = 4'h3;
  localparam logic [3:0] OP_OR   = 4'h4;
  localparam logic [3:0] OP_AND  = 4'h5;
  localparam logic [3:0] OP_LSH  = 4'h6;
  localparam logic [3:0] OP_RSH  = 4'h7;
  localparam logic [3:0] OP_NEG  = 4'h8;
  localparam logic [3:0] OP_MOD  = 4'h9;
  localparam logic [3:0] OP_XOR  = 4'hA;
  localparam logic [3:0] OP_MOV  = 4'hB;
  localparam logic [3:0] OP_ARSH = 4'hC;
  localparam logic [3:0] OP_SWAP = 4'hD;

  typedef enum logic [1:0] {
    SWAP_W16 = 2'd0,
    SWAP_W32 = 2'd1,
    SWAP_W64 = 2'd2
  } swap_width_e;
endpackage

// File: rtl/vm_alu_operand.sv
module vm_alu_operand #(
  parameter int W = 64
) (
  input  logic             is64,
  input  logic             src_sel,
  input  logic [W-1:0]     dst_val,
  input  logic [W-1:0]     src_val,
  input  logic [W/2-1:0]   imm,
  output logic [W-1:0]     opa,
  output logic [W-1:0]     opb
);
  localparam int H = W / 2;

  logic [W-1:0] opb_raw;

  always_comb begin
    opb_raw = src_sel ? src_val : {{H{imm[H-1]}}, imm};
    opa     = is64 ? dst_val : {{H{1'b0}}, dst_val[H-1:0]};
    opb     = is64 ? opb_raw : {{H{1'b0}}, opb_raw[H-1:0]};
  end
endmodule

// File: rtl/vm_alu_simple.sv
module vm_alu_simple
  import vm_alu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [3:0]   op,
  input  logic         is64,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res
);
  localparam int H  = W / 2;
  localparam int SW = $clog2(W);

  logic [SW-1:0] shamt;
  logic [W-1:0]  a_sx;
  logic [W-1:0]  raw;

  always_comb begin
    shamt = is64 ? opb[SW-1:0] : {1'b0, opb[SW-2:0]};
    a_sx  = is64 ? opa : {{H{opa[H-1]}}, opa[H-1:0]};
    case (op)
      OP_ADD:  raw = opa + opb;
      OP_SUB:  raw = opa - opb;
      OP_MUL:  raw = opa * opb;
      OP_OR:   raw = opa | opb;
      OP_AND:  raw = opa & opb;
      OP_LSH:  raw = opa << shamt;
      OP_RSH:  raw = opa >> shamt;
      OP_NEG:  raw = '0 - opa;
      OP_XOR:  raw = opa ^ opb;
      OP_MOV:  raw = opb;
      OP_ARSH: raw = $signed(a_sx) >>> shamt;
      default: raw = opa;
    endcase
    res = is64 ? raw : {{H{1'b0}}, raw[H-1:0]};
  end
endmodule

// File: rtl/vm_alu_bswap.sv
module vm_alu_bswap
  import vm_alu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]   data,
  input  logic [W/2-1:0] imm,
  input  logic           to_be,
  output logic [W-1:0]   res
);
  localparam int NB = W / 8;

  swap_width_e  wsel;
  logic [W-1:0] rev16;
  logic [W-1:0] rev32;
  logic [W-1:0] rev_all;

  always_comb begin
    if (imm == (W/2)'(16))      wsel = SWAP_W16;
    else if (imm == (W/2)'(32)) wsel = SWAP_W32;
    else                        wsel = SWAP_W64;

    rev16 = '0;
    rev32 = '0;
    for (int k = 0; k < 2; k++)  rev16[k*8 +: 8]   = data[(1-k)*8 +: 8];
    for (int k = 0; k < 4; k++)  rev32[k*8 +: 8]   = data[(3-k)*8 +: 8];
    for (int k = 0; k < NB; k++) rev_all[k*8 +: 8] = data[(NB-1-k)*8 +: 8];

    case (wsel)
      SWAP_W16: res = to_be ? rev16 : {{(W-16){1'b0}}, data[15:0]};
      SWAP_W32: res = to_be ? rev32 : {{(W-32){1'b0}}, data[31:0]};
      default:  res = to_be ? rev_all : data;
    endcase
  end
endmodule

// File: rtl/vm_alu_div.sv
module vm_alu_div #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is64,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int H  = W / 2;
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(W);
  localparam logic [CW-1:0] CNT_HALF = CW'(H);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          fin_q, fin_d;
  logic [W:0]    rem_sh;
  logic [W:0]    diff;

  always_comb begin
    rem_sh = {rem_q, quo_q[W-1]};
    diff   = rem_sh - {1'b0, dvs_q};
    quo_d  = quo_q;
    rem_d  = rem_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fin_d  = 1'b0;
    if (start) begin
      quo_d  = is64 ? dividend : (dividend << H);
      rem_d  = '0;
      dvs_d  = divisor;
      cnt_d  = is64 ? CNT_FULL : CNT_HALF;
      busy_d = 1'b1;
    end else if (busy_q) begin
      quo_d = {quo_q[W-2:0], ~diff[W]};
      rem_d = diff[W] ? rem_sh[W-1:0] : diff[W-1:0];
      cnt_d = cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      fin_q  <= fin_d;
    end
  end

  assign busy = busy_q;
  assign fin  = fin_q;
  assign quo  = quo_q;
  assign rem  = rem_q;
endmodule

// File: rtl/vm_alu.sv
module vm_alu
  import vm_alu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [3:0]     op,
  input  logic           is64,
  input  logic           src_sel,
  input  logic [W-1:0]   dst_val,
  input  logic [W-1:0]   src_val,
  input  logic [W/2-1:0] imm,
  output logic           busy,
  output logic           done,
  output logic           wr_en,
  output logic [W-1:0]   result
);
  localparam int H = W / 2;

  logic [W-1:0] opa, opb;
  logic [W-1:0] simple_res, swap_res;
  logic [W-1:0] dv_quo, dv_rem;
  logic         dv_busy, dv_fin, dv_start;
  logic         accept, is_divop, zero_div, unused_op;
  logic [W-1:0] res_q, res_d, dv_pick;
  logic         done_q, done_d, wen_q, wen_d;
  logic         mod_q, mod_d, w64_q, w64_d;

  vm_alu_operand #(.W(W)) u_operand (
    .is64(is64), .src_sel(src_sel), .dst_val(dst_val), .src_val(src_val),
    .imm(imm), .opa(opa), .opb(opb)
  );

  vm_alu_simple #(.W(W)) u_simple (
    .op(op), .is64(is64), .opa(opa), .opb(opb), .res(simple_res)
  );

  vm_alu_bswap #(.W(W)) u_bswap (
    .data(dst_val), .imm(imm), .to_be(src_sel), .res(swap_res)
  );

  vm_alu_div #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(dv_start), .is64(is64),
    .dividend(opa), .divisor(opb), .busy(dv_busy), .fin(dv_fin),
    .quo(dv_quo), .rem(dv_rem)
  );

  assign busy = dv_busy | dv_fin;

  always_comb begin
    accept    = start && !busy;
    is_divop  = (op == OP_DIV) || (op == OP_MOD);
    zero_div  = (opb == '0);
    unused_op = (op == 4'hE) || (op == 4'hF);
    dv_pick   = mod_q ? dv_rem : dv_quo;

    res_d    = res_q;
    done_d   = 1'b0;
    wen_d    = 1'b0;
    mod_d    = mod_q;
    w64_d    = w64_q;
    dv_start = 1'b0;

    if (dv_fin) begin
      done_d = 1'b1;
      wen_d  = 1'b1;
      res_d  = w64_q ? dv_pick : {{H{1'b0}}, dv_pick[H-1:0]};
    end else if (accept) begin
      if (is_divop && !zero_div) begin
        dv_start = 1'b1;
        mod_d    = (op == OP_MOD);
        w64_d    = is64;
      end else begin
        done_d = 1'b1;
        if (is_divop || unused_op) begin
          res_d = dst_val;
          wen_d = 1'b0;
        end else if (op == OP_SWAP) begin
          res_d = swap_res;
          wen_d = 1'b1;
        end else begin
          res_d = simple_res;
          wen_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
      wen_q  <= 1'b0;
      mod_q  <= 1'b0;
      w64_q  <= 1'b0;
    end else begin
      res_q  <= res_d;
      done_q <= done_d;
      wen_q  <= wen_d;
      if (dv_start) begin
        mod_q <= mod_d;
        w64_q <= w64_d;
      end
    end
  end

  assign done   = done_q;
  assign wr_en  = wen_q;
  assign result = res_q;
endmodule

// File: rtl/vm_alu_chk.sv
module vm_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  op,
  input logic        is64,
  input logic        src_sel,
  input logic [63:0] dst_val,
  input logic [63:0] src_val,
  input logic [31:0] imm,
  input logic        busy,
  input logic        done,
  input logic        wr_en,
  input logic [63:0] result
);
  logic        acc, divop;
  logic [63:0] b_eff, b_cls;

  always_comb begin
    acc   = start && !busy;
    divop = (op == 4'h3) || (op == 4'h9);
    b_eff = src_sel ? src_val : {{32{imm[31]}}, imm};
    b_cls = is64 ? b_eff : {32'b0, b_eff[31:0]};
  end

  assert_zero_div_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && divop && b_cls == 64'd0) |=> (done && !wr_en && result == $past(dst_val)));

  assert_single_cycle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !divop) |=> done);

  assert_wren_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);

  assert_div_goes_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && divop && b_cls != 64'd0) |=> (busy && !done));

  assert_no_done_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  assert_upper_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !is64 && !divop && op != 4'hD && op != 4'hE && op != 4'hF)
      |=> (result[63:32] == 32'd0));
endmodule

bind vm_alu vm_alu_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .is64(is64),
  .src_sel(src_sel), .dst_val(dst_val), .src_val(src_val), .imm(imm),
  .busy(busy), .done(done), .wr_en(wr_en), .result(result)
);

// File: tb/vm_alu_tb_top.sv
module vm_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  op;
  logic        is64;
  logic        src_sel;
  logic [63:0] dst_val;
  logic [63:0] src_val;
  logic [31:0] imm;
  logic        busy, done, wr_en;
  logic [63:0] result;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vm_alu dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .is64(is64),
    .src_sel(src_sel), .dst_val(dst_val), .src_val(src_val), .imm(imm),
    .busy(busy), .done(done), .wr_en(wr_en), .result(result)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic w64, input logic ss,
                       input logic [63:0] d, input logic [63:0] s, input logic [31:0] i,
                       output logic [63:0] res, output logic wen, output int cyc);
    @(negedge clk);
    start = 1'b1; op = o; is64 = w64; src_sel = ss;
    dst_val = d; src_val = s; imm = i;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    res = result;
    wen = wr_en;
  endtask

  task automatic expect_op(string tag, input logic [3:0] o, input logic w64, input logic ss,
                           input logic [63:0] d, input logic [63:0] s, input logic [31:0] i,
                           input logic [63:0] exp, input int exp_cyc);
    logic [63:0] r;
    logic        we;
    int          c;
    issue(o, w64, ss, d, s, i, r, we, c);
    chk({tag, " result"}, r, exp);
    chk({tag, " wr_en"}, {63'd0, we}, 64'd1);
    chk({tag, " latency"}, 64'(c), 64'(exp_cyc));
  endtask

  task automatic t_reset();
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 wr_en", {63'd0, wr_en}, 64'd0);
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 result", result, 64'd0);
  endtask

  task automatic t_arith64();
    expect_op("R2 add wrap", 4'h0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0, 64'd1, 1);
    expect_op("R2 sub wrap", 4'h1, 1, 1, 64'd0, 64'd1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    expect_op("R2 mul wrap", 4'h2, 1, 1, 64'h0000_0001_0000_0000,
              64'h0000_0001_0000_0001, 0, 64'h0000_0001_0000_0000, 1);
  endtask

  task automatic t_arith32();
    expect_op("R3 add32 wrap", 4'h0, 0, 1, 64'h0000_0001_FFFF_FFFF, 64'd1, 0, 64'd0, 1);
    expect_op("R3 sub32 wrap", 4'h1, 0, 1, 64'd0, 64'd1, 0, 64'h0000_0000_FFFF_FFFF, 1);
    expect_op("R3 mul32 trunc", 4'h2, 0, 1, 64'h1_0000, 64'h1_0001, 0, 64'h1_0000, 1);
  endtask

  task automatic t_imm();
    expect_op("R4 add imm -1", 4'h0, 1, 0, 64'd5, 64'hDEAD, 32'hFFFF_FFFF, 64'd4, 1);
    expect_op("R4 mov64 imm sext", 4'hB, 1, 0, 64'd0, 64'd0, 32'h8000_0000,
              64'hFFFF_FFFF_8000_0000, 1);
    expect_op("R4 mov32 imm", 4'hB, 0, 0, 64'd0, 64'd0, 32'h8000_0000,
              64'h0000_0000_8000_0000, 1);
    expect_op("R4 mov reg", 4'hB, 1, 1, 64'd0, 64'h0123_4567_89AB_CDEF, 32'd7,
              64'h0123_4567_89AB_CDEF, 1);
  endtask

  task automatic t_logic();
    expect_op("R5 or", 4'h4, 1, 1, 64'hF0F0, 64'h0F0F, 0, 64'hFFFF, 1);
    expect_op("R5 and", 4'h5, 1, 1, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0, 0,
              64'h0F00_0F00_0F00_0F00, 1);
    expect_op("R5 xor", 4'hA, 1, 1, 64'hAAAA, 64'hFFFF, 0, 64'h5555, 1);
    expect_op("R5 xor32 imm", 4'hA, 0, 0, 64'hFFFF_FFFF_0000_1234, 64'd0, 32'hFFFF_FFFF,
              64'h0000_0000_FFFF_EDCB, 1);
    expect_op("R5 neg64", 4'h8, 1, 1, 64'd1, 64'd0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    expect_op("R5 neg32", 4'h8, 0, 1, 64'd1, 64'd0, 0, 64'h0000_0000_FFFF_FFFF, 1);
  endtask

  task automatic t_shift();
    expect_op("R6 lsh64 63", 4'h6, 1, 1, 64'd1, 64'd63, 0, 64'h8000_0000_0000_0000, 1);
    expect_op("R6 lsh64 mask", 4'h6, 1, 1, 64'd1, 64'd67, 0, 64'd8, 1);
    expect_op("R6 lsh32 31", 4'h6, 0, 1, 64'd1, 64'd31, 0, 64'h8000_0000, 1);
    expect_op("R6 lsh32 mask", 4'h6, 0, 1, 64'd1, 64'd33, 0, 64'd2, 1);
    expect_op("R6 rsh32", 4'h7, 0, 1, 64'hFFFF_FFFF_8000_0000, 64'd4, 0, 64'h0800_0000, 1);
    expect_op("R6 arsh64", 4'hC, 1, 1, 64'h8000_0000_0000_0000, 64'd4, 0,
              64'hF800_0000_0000_0000, 1);
    expect_op("R6 arsh32", 4'hC, 0, 1, 64'h0000_0000_8000_0000, 64'd4, 0,
              64'h0000_0000_F800_0000, 1);
  endtask

  task automatic t_div();
    expect_op("R7 div64", 4'h3, 1, 1, 64'd100, 64'd7, 0, 64'd14, 66);
    expect_op("R7 mod64", 4'h9, 1, 1, 64'd100, 64'd7, 0, 64'd2, 66);
    expect_op("R7 div64 full", 4'h3, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0,
              64'h5555_5555_5555_5555, 66);
    expect_op("R7 div32", 4'h3, 0, 1, 64'h0000_0001_0000_000A, 64'd3, 0, 64'd3, 34);
    expect_op("R7 mod32", 4'h9, 0, 1, 64'h0000_0001_0000_000A, 64'd3, 0, 64'd1, 34);
  endtask

  task automatic t_zero();
    logic [63:0] r;
    logic        we;
    int          c;
    issue(4'h3, 1, 1, 64'h1234_5678_9ABC_DEF0, 64'd0, 0, r, we, c);
    chk("R8 div0 result", r, 64'h1234_5678_9ABC_DEF0);
    chk("R8 div0 wr_en", {63'd0, we}, 64'd0);
    chk("R8 div0 latency", 64'(c), 64'd1);
    issue(4'h9, 0, 1, 64'hAAAA_BBBB_CCCC_DDDD, 64'h0000_0001_0000_0000, 0, r, we, c);
    chk("R8 mod32 low-zero result", r, 64'hAAAA_BBBB_CCCC_DDDD);
    chk("R8 mod32 low-zero wr_en", {63'd0, we}, 64'd0);
    issue(4'hE, 1, 1, 64'h55, 64'h66, 0, r, we, c);
    chk("R8 code E result", r, 64'h55);
    chk("R8 code E wr_en", {63'd0, we}, 64'd0);
  endtask

  task automatic t_swap();
    logic [63:0] d;
    d = 64'h1122_3344_5566_7788;
    expect_op("R9 le16", 4'hD, 1, 0, d, 0, 32'd16, 64'h7788, 1);
    expect_op("R9 be16", 4'hD, 1, 1, d, 0, 32'd16, 64'h8877, 1);
    expect_op("R9 le32", 4'hD, 1, 0, d, 0, 32'd32, 64'h5566_7788, 1);
    expect_op("R9 be32", 4'hD, 1, 1, d, 0, 32'd32, 64'h8877_6655, 1);
    expect_op("R9 le64", 4'hD, 1, 0, d, 0, 32'd64, d, 1);
    expect_op("R9 be64", 4'hD, 1, 1, d, 0, 32'd64, 64'h8877_6655_4433_2211, 1);
    expect_op("R9 be64 in 32-bit class", 4'hD, 0, 1, d, 0, 32'd64,
              64'h8877_6655_4433_2211, 1);
  endtask

  task automatic t_busy();
    int          ndone = 0;
    int          cdone = 0;
    logic [63:0] rres  = '0;
    @(negedge clk);
    start = 1'b1; op = 4'h3; is64 = 1'b1; src_sel = 1'b1;
    dst_val = 64'd100; src_val = 64'd7; imm = 0;
    @(negedge clk);
    op = 4'h0; dst_val = 64'd1; src_val = 64'd1;
    for (int c = 1; c <= 80; c++) begin
      if (done) begin
        ndone++;
        cdone = c;
        rres  = result;
      end
      if (c == 60) start = 1'b0;
      @(negedge clk);
    end
    chk("R11 single done", 64'(ndone), 64'd1);
    chk("R11 divide result kept", rres, 64'd14);
    chk("R11 done cycle", 64'(cdone), 64'd66);
  endtask

  task automatic t_latency();
    logic [63:0] r;
    logic        we;
    int          c;
    issue(4'h0, 1, 1, 64'd3, 64'd4, 0, r, we, c);
    chk("R10 one-cycle done", 64'(c), 64'd1);
    @(negedge clk);
    chk("R10 done is a pulse", {63'd0, done}, 64'd0);
    chk("R10 wr_en low without done", {63'd0, wr_en}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 4'h0; is64 = 1'b1; src_sel = 1'b1;
    dst_val = '0; src_val = '0; imm = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_arith64();
    t_arith32();
    t_imm();
    t_logic();
    t_shift();
    t_div();
    t_zero();
    t_swap();
    t_busy();
    t_latency();
    finish_run();
  end
endmodule